// File: doc/BRIEF.md
# Asynchronous Bus Cycle Controller

This block is the processor-side sequencer for one asynchronous transfer on a 32-bit non-multiplexed data bus. The core presents a request with a direction, an address, an operand size and, for writes, a data word. The controller then steps the bus control lines through half-clock phases, using both clock edges. These lines are the address strobe, the data strobe, the data buffer enable and the write-data output enable. It then waits for the two-bit acknowledge code from the slave.

Reads and writes use different strobe orders. On a read, the data strobe rises together with the address strobe. On a write, the data strobe comes a full clock later, and the write word is placed on the bus half a clock after the address strobe. When the slave acknowledges, the controller captures read data and releases the strobes on the next half-clock phase. It then reports the acknowledged port width for one clock. Port sizing and splitting into further cycles is left to the requester.

Top module: `async_bus_ctrl`

## Requirements
- R1: Under reset `busy`, `rsp_done`, `addr_strobe`, `data_strobe`, `buf_en` and `dout_en` are all 0.
- R2: A request is taken on a rising edge only while `busy` is 0. `busy` is 1 from that edge until the cycle ends. Requests made while `busy` is 1 are ignored, and `bus_addr` keeps the accepted address.
- R3: On a read, `addr_strobe` and `data_strobe` both go to 1 on the falling edge half a clock after acceptance.
- R4: On a write, `addr_strobe` goes to 1 on the falling edge half a clock after acceptance. `data_strobe` goes to 1 one full clock later.
- R5: On a write, `dout_en` goes to 1 on the rising edge half a clock after `addr_strobe`. `dout` then carries the whole 32-bit `req_wdata` word, whatever the `req_size` value. `req_size` encodes bytes as value+1. `dout_en` drops when the cycle ends.
- R6: On a read, `buf_en` goes to 1 on the rising edge one clock after acceptance and drops together with `data_strobe`. On a write, `buf_en` rises and falls with `addr_strobe`.
- R7: `ack` is sampled only on falling edges, starting one clock after `addr_strobe` rises. Code 00 inserts a wait state. A nonzero code that appears and is removed between two falling edges has no effect.
- R8: After a nonzero `ack` is sampled, `addr_strobe`, `data_strobe`, `buf_en` and `dout_en` drop on the next rising edge. `busy` drops on that same edge.
- R9: `rsp_done` is 1 for exactly one clock, starting at the edge where the cycle ends. At the same time, `rsp_port_bytes` gives the acknowledged port width: 01 gives 1, 10 gives 2, 11 gives 4.
- R10: On a read, `dbus_in` is captured on the falling edge where the ending acknowledge is sampled. It is presented on `rsp_rdata` while `rsp_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, both edges used |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Transfer address |
| req_size | input | 2 | Operand bytes minus one |
| req_wdata | input | 32 | Write word |
| busy | output | 1 | Cycle in progress |
| bus_addr | output | 32 | Address on the bus |
| bus_size | output | 2 | Operand size on the bus |
| bus_write | output | 1 | Direction on the bus |
| addr_strobe | output | 1 | Address strobe, active high |
| data_strobe | output | 1 | Data strobe, active high |
| buf_en | output | 1 | External data buffer enable |
| dout | output | 32 | Write data lines |
| dout_en | output | 1 | Write data output enable |
| dbus_in | input | 32 | Read data lines |
| ack | input | 2 | Acknowledge and port width code |
| rsp_done | output | 1 | Cycle finished pulse |
| rsp_port_bytes | output | 3 | Acknowledged port width in bytes |
| rsp_rdata | output | 32 | Captured read data |

## Verification
Two functions can fall on the same falling edge. These are the first chance to sample the acknowledge and, on a write, the late assertion of the data strobe. The bench provokes this with zero-wait writes, which must show a data strobe lasting only half a clock before the release. Two further functions meet on the ending rising edge: releasing the strobes and being ready for a new request. The bench judges this by holding a competing request through a busy cycle and checking that neither the address nor `busy` moves. A phase-by-phase reference model checks every half clock.

// File: rtl/bcc_pkg.sv
// Package: shared acknowledge codes and port-width decode for the
// asynchronous bus cycle controller.
package bcc_pkg;

    typedef enum logic [1:0] {
        ACK_WAIT = 2'b00,
        ACK_P8   = 2'b01,
        ACK_P16  = 2'b10,
        ACK_P32  = 2'b11
    } ack_code_e;

    // Converts an acknowledge code to the port width in bytes.
    function automatic logic [2:0] port_bytes(input logic [1:0] code);
        case (ack_code_e'(code))
            ACK_P8:  return 3'd1;
            ACK_P16: return 3'd2;
            ACK_P32: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/bcc_cycle_seq.sv
// Rising-edge half of the controller. It accepts requests while idle,
// holds the request fields, marks the phase that starts one clock into
// the cycle, and closes the cycle once the falling-edge half reports an
// acknowledge. Assumes ack_seen is a falling-edge register.
module bcc_cycle_seq #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ack_seen,
    input  logic [1:0]        ack_code,
    output logic              active,
    output logic              phase1,
    output logic              write_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [1:0]        size_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              done,
    output logic [2:0]        done_bytes
);
    import bcc_pkg::*;

    // Cycle control: accept, advance to the second phase, close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            phase1     <= 1'b0;
            done       <= 1'b0;
            done_bytes <= '0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                phase1 <= 1'b0;
                if (req_valid) active <= 1'b1;
            end else if (ack_seen) begin
                active     <= 1'b0;
                phase1     <= 1'b0;
                done       <= 1'b1;
                done_bytes <= port_bytes(ack_code);
            end else begin
                phase1 <= 1'b1;
            end
        end
    end

    // Request field hold: loaded only when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            addr_q  <= '0;
            size_q  <= '0;
            wdata_q <= '0;
        end else if (!active && req_valid) begin
            write_q <= req_write;
            addr_q  <= req_addr;
            size_q  <= req_size;
            wdata_q <= req_wdata;
        end
    end

    p_done_one_clock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones(done_bytes) == 1));

endmodule

// File: rtl/bcc_strobe_gen.sv
// Falling-edge half of the controller. It raises the address strobe half
// a clock into the cycle, delays the write data strobe by one clock, and
// samples the acknowledge from one clock after the address strobe. Read
// data is captured on the sampling edge that sees a nonzero code.
// Assumes active comes from a rising-edge register.
module bcc_strobe_gen #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              write_q,
    input  logic [1:0]        ack,
    input  logic [DATA_W-1:0] dbus_in,
    output logic              as_q,
    output logic              dsw_q,
    output logic              ack_seen,
    output logic [1:0]        ack_code,
    output logic [DATA_W-1:0] rdata_q
);
    logic sample_hit;
    assign sample_hit = active && as_q && !ack_seen && (ack != 2'b00);

    // Strobe phases and acknowledge sampling on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            as_q     <= 1'b0;
            dsw_q    <= 1'b0;
            ack_seen <= 1'b0;
            ack_code <= 2'b00;
        end else begin
            as_q     <= active;
            dsw_q    <= active && as_q;
            ack_seen <= sample_hit;
            if (sample_hit) ack_code <= ack;
        end
    end

    // Read data capture on the ending falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (sample_hit && !write_q) rdata_q <= dbus_in;
    end

endmodule

// File: rtl/async_bus_ctrl.sv
// Top of the asynchronous bus cycle controller. It combines the
// rising-edge sequencer and the falling-edge strobe generator; each
// strobe is gated with the rising-edge active flag so that it is
// released on the rising edge after an acknowledge. One transfer at a
// time; port sizing is left to the requester.
module async_bus_ctrl #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic              bus_write,
    output logic              addr_strobe,
    output logic              data_strobe,
    output logic              buf_en,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    input  logic [DATA_W-1:0] dbus_in,
    input  logic [1:0]        ack,
    output logic              rsp_done,
    output logic [2:0]        rsp_port_bytes,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic       active, phase1, write_q, as_q, dsw_q, ack_seen;
    logic [1:0] ack_code;

    bcc_cycle_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .ack_seen(ack_seen), .ack_code(ack_code),
        .active(active), .phase1(phase1), .write_q(write_q),
        .addr_q(bus_addr), .size_q(bus_size), .wdata_q(dout),
        .done(rsp_done), .done_bytes(rsp_port_bytes)
    );

    bcc_strobe_gen #(.DATA_W(DATA_W)) u_strb (
        .clk(clk), .rst_n(rst_n), .active(active), .write_q(write_q),
        .ack(ack), .dbus_in(dbus_in), .as_q(as_q), .dsw_q(dsw_q),
        .ack_seen(ack_seen), .ack_code(ack_code), .rdata_q(rsp_rdata)
    );

    // Output gating: falling-edge phases cut off by the rising-edge flag.
    always_comb begin
        busy        = active;
        bus_write   = write_q;
        addr_strobe = as_q && active;
        data_strobe = write_q ? (dsw_q && active) : addr_strobe;
        buf_en      = write_q ? addr_strobe : (phase1 && active);
        dout_en     = write_q && phase1 && active;
    end

    p_read_ds_with_as_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_write && addr_strobe) |-> data_strobe);
    p_write_ds_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_write && data_strobe) |-> $past(addr_strobe));
    p_oe_inside_buf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> buf_en);
    p_addr_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(bus_addr));
    p_release_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (!addr_strobe && !data_strobe && !buf_en && !dout_en && !busy));

endmodule

// File: tb/async_bus_ctrl_test.sv
module async_bus_ctrl_test;
    logic        clk = 0, rst_n = 0;
    logic        req_valid = 0, req_write = 0;
    logic [31:0] req_addr = 0, req_wdata = 0, dbus_in = 0;
    logic [1:0]  req_size = 0, ack = 0;
    logic        busy, bus_write, addr_strobe, data_strobe, buf_en, dout_en, rsp_done;
    logic [31:0] bus_addr, dout, rsp_rdata;
    logic [1:0]  bus_size;
    logic [2:0]  rsp_port_bytes;
    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    async_bus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .busy(busy), .bus_addr(bus_addr), .bus_size(bus_size), .bus_write(bus_write),
        .addr_strobe(addr_strobe), .data_strobe(data_strobe), .buf_en(buf_en),
        .dout(dout), .dout_en(dout_en), .dbus_in(dbus_in), .ack(ack),
        .rsp_done(rsp_done), .rsp_port_bytes(rsp_port_bytes), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compares all control outputs against expected phase values.
    task automatic phase(input string tag, input bit b, input bit a, input bit d,
                         input bit be, input bit oe, input bit dn);
        chk({tag, " R2 busy"}, 32'(busy), 32'(b));
        chk({tag, " R3/R4 as"}, 32'(addr_strobe), 32'(a));
        chk({tag, " R3/R4 ds"}, 32'(data_strobe), 32'(d));
        chk({tag, " R6 buf_en"}, 32'(buf_en), 32'(be));
        chk({tag, " R5 dout_en"}, 32'(dout_en), 32'(oe));
        chk({tag, " R9 done"}, 32'(rsp_done), 32'(dn));
    endtask

    // Behavioural model of one transfer: w=write, n wait states, code=ack,
    // glitch puts a nonzero ack pulse between falling edges (R7),
    // intr raises a competing request during the cycle (R2).
    task automatic xfer(input bit w, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input int n, input logic [1:0] code,
                        input bit glitch, input bit intr);
        logic [31:0] rd;
        int bytes;
        rd = $urandom;
        bytes = (code == 2'b01) ? 1 : (code == 2'b10) ? 2 : 4;
        @(negedge clk); #1;
        req_valid = 1; req_write = w; req_addr = a; req_size = sz; req_wdata = wd;
        dbus_in = rd;
        @(posedge clk); #1;
        phase("E0", 1, 0, 0, 0, 0, 0);
        chk("R2 addr", bus_addr, a);
        chk("R2 size", 32'(bus_size), 32'(sz));
        chk("R2 dir", 32'(bus_write), 32'(w));
        req_valid = intr; req_addr = ~a; req_write = ~w;
        @(negedge clk); #1;
        phase("F0", 1, 1, !w, w, 0, 0);
        @(posedge clk); #1;
        phase("E1", 1, 1, !w, 1, w, 0);
        if (w) chk("R5 dout", dout, wd);
        for (int j = 0; j <= n; j++) begin
            ack = (j == n) ? code : 2'b00;
            if (j == n) req_valid = 0;
            @(negedge clk); #1;
            phase("F", 1, 1, 1, 1, w, 0);
            chk("R2 addr held", bus_addr, a);
            if (j < n) begin
                if (glitch) ack = 2'b11;
                @(posedge clk); #1;
                phase("Ew R7", 1, 1, 1, 1, w, 0);
                ack = 2'b00;
            end
        end
        dbus_in = ~rd;
        @(posedge clk); #1;
        ack = 2'b00;
        phase("Eend R8", 0, 0, 0, 0, 0, 1);
        chk("R9 width", 32'(rsp_port_bytes), 32'(bytes));
        if (!w) chk("R10 rdata", rsp_rdata, rd);
        @(posedge clk); #1;
        phase("after R9", 0, 0, 0, 0, 0, 0);
        if (intr) chk("R2 no restart", bus_addr, a);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        phase("reset R1", 0, 0, 0, 0, 0, 0);
        rst_n = 1;
        @(posedge clk); #1;
        phase("idle R1", 0, 0, 0, 0, 0, 0);
        xfer(0, 32'h1000_0000, 2'd0, 32'h0, 0, 2'b01, 0, 0);
        xfer(0, 32'h2000_0004, 2'd3, 32'h0, 2, 2'b10, 1, 0);
        xfer(1, 32'h3000_0008, 2'd0, 32'hA5A5_1234, 0, 2'b11, 0, 0);
        xfer(1, 32'h4000_000C, 2'd3, 32'hDEAD_BEEF, 3, 2'b01, 1, 1);
        xfer(1, 32'h5000_0010, 2'd1, 32'h0BAD_F00D, 1, 2'b10, 0, 0);
        xfer(0, 32'h6000_0014, 2'd2, 32'h0, 1, 2'b11, 0, 1);
        xfer(0, 32'h7000_0018, 2'd1, 32'h0, 4, 2'b10, 1, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #20000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule